// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Buffer

This block turns a logical address issued by a processor into a physical address under a single-level paging scheme. The logical address is split into a page number (upper bits) and a byte offset (lower `PG_BITS` bits). The page number is searched in parallel across a small, fully associative lookaside buffer. On a hit, the stored frame number is joined to the untouched offset and returned on the next cycle.

On a miss, the block checks the page number against a length register. It then reads one page-table entry from memory at `base + page` over a request/acknowledge port. The entry is decoded, checked for validity and protection, and, if valid, written into the buffer. Each response carries a physical address or a two-bit fault cause. Software switches address space by writing the base register. Any write to the base or length register empties the whole buffer.

The page size is `2**PG_BITS` bytes. `PG_BITS` must be between 9 and 13 (512 to 8192 bytes).

Top module: `pgxlate_unit`

## Requirements
- R1: For a permitted access, `rsp_paddr` is the frame number shifted left by `PG_BITS`, OR'd with the logical offset `req_vaddr[PG_BITS-1:0]`, which passes through unchanged. On any fault, `rsp_paddr` is zero.
- R2: A request accepted (`req_valid` high while `busy` is low) whose page is resident in the buffer gets its response exactly one cycle after acceptance. No memory read is issued for it, and at most one buffer entry ever matches a page.
- R3: For an in-bounds request that misses, the block issues exactly one read with `mem_addr = base + page`. It holds `mem_req` and `mem_addr` steady until `mem_ack`, and responds on the cycle after the acknowledge.
- R4: When the page number is greater than or equal to the length register, the block responds one cycle later with fault code 1 (bounds) and issues no memory read.
- R5: Page-table entry layout is `{prot[1:0], valid, frame[PFN_W-1:0]}` with the frame in the low bits. An entry whose valid bit is 0 yields fault code 2 (invalid). Such an entry is not stored, so the next access to that page reads memory again.
- R6: Access kinds are 0 = read, 1 = write, 2 = fetch; kind 3 is always refused. Protection codes are 0 = read-only (read and fetch allowed), 1 = read-write (read, write and fetch allowed), 2 = execute-only (fetch only) and 3 = no access. A refused access yields fault code 3; fault code 0 means success.
- R7: Writing the base register (`cfg_sel` = 0) or the length register (`cfg_sel` = 1) empties every buffer entry. A fill whose walk overlaps such a write is dropped.
- R8: Valid fetched entries are placed at a round-robin pointer. The pointer starts at slot 0 after reset or a flush and advances by one on each fill, so the oldest fill is replaced first.
- R9: `busy` is high from the cycle after a miss is accepted until the cycle its response appears. Requests presented while `busy` is high are ignored and produce no response or read.
- R10: After reset the buffer is empty, `busy`, `rsp_valid` and `mem_req` are low, and base and length are zero, so every access is out of bounds until the length is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | LA_W | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| busy | output | 1 | Table walk in progress; requests ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 base register, 1 length register |
| cfg_wdata | input | MEM_AW | Register write data |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MEM_AW | Page-table entry address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | PA_W-PG_BITS+3 | Page-table entry |

## Verification
The bench builds the unit with 12-bit logical addresses, 512-byte pages (eight pages), 4-bit frames, 8-bit table addresses and only four buffer slots. Eight pages against four slots forces round-robin eviction during a sweep of every page with every access kind. The arithmetically generated table makes invalid entries and all four protection codes appear under two different bases. A length of six puts the bounds edge at pages 5 and 6, and a length of eight makes the top page legal.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_BOUNDS  = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROT    = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    PR_RO   = 2'd0,
    PR_RW   = 2'd1,
    PR_XO   = 2'd2,
    PR_NONE = 2'd3
  } prot_e;

  // Permission table: which access kinds a protection code admits.
  function automatic logic prot_allows(input logic [1:0] prot, input logic [1:0] acc);
    logic ok;
    case (prot_e'(prot))
      PR_RO:   ok = (acc == ACC_READ) || (acc == ACC_FETCH);
      PR_RW:   ok = (acc != ACC_RSVD);
      PR_XO:   ok = (acc == ACC_FETCH);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [1:0] prot_fault(input logic [1:0] prot, input logic [1:0] acc);
    return prot_allows(prot, acc) ? FLT_NONE : FLT_PROT;
  endfunction

endpackage

// File: rtl/pgx_cfg.sv
module pgx_cfg #(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  output logic [MEM_AW-1:0] base,
  output logic [MEM_AW-1:0] len,
  output logic              flush
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      len  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) len  <= cfg_wdata;
      else         base <= cfg_wdata;
    end
  end

  // Entries carry no address-space tag, so any register write empties the buffer.
  assign flush = cfg_we;

endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 4,
  parameter int PFN_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               hit,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic [1:0]         hit_prot,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic [1:0]         fill_prot,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [PFN_W-1:0] pfn_q  [ENTRIES];
  logic [1:0]       prot_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = fill_en && (ptr_q == PTR_W'(e));
    assign match_vec[e] = vld_q[e] && (tag_q[e] == look_vpn);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[e] <= 1'b0;
      else if (flush)  vld_q[e] <= 1'b0;
      else if (sel)    vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel && !flush) begin
        tag_q[e]  <= fill_vpn;
        pfn_q[e]  <= fill_pfn;
        prot_q[e] <= fill_prot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (flush)   ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    hit_pfn  = '0;
    hit_prot = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) begin
        hit_pfn  = hit_pfn  | pfn_q[e];
        hit_prot = hit_prot | prot_q[e];
      end
    end
  end

  assign hit       = |match_vec;
  assign valid_vec = vld_q;

endmodule

// File: rtl/pgx_walker.sv
module pgx_walker #(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] start_addr,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (start) begin
      mem_req  <= 1'b1;
      mem_addr <= start_addr;
    end else if (mem_req && mem_ack) begin
      mem_req  <= 1'b0;
    end
  end

  assign done = mem_req && mem_ack;

endmodule

// File: rtl/pgxlate_unit.sv
module pgxlate_unit #(
  parameter int LA_W    = 16,
  parameter int PG_BITS = 12,
  parameter int PA_W    = 20,
  parameter int TLB_N   = 8,
  parameter int MEM_AW  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [LA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic [PA_W-1:0]           rsp_paddr,
  output logic [1:0]                rsp_fault,
  input  logic                      cfg_we,
  input  logic                      cfg_sel,
  input  logic [MEM_AW-1:0]         cfg_wdata,
  output logic                      mem_req,
  output logic [MEM_AW-1:0]         mem_addr,
  input  logic                      mem_ack,
  input  logic [PA_W-PG_BITS+2:0]   mem_rdata
);
  import pgx_pkg::*;

  localparam int VPN_W = LA_W - PG_BITS;
  localparam int PFN_W = PA_W - PG_BITS;

  // Arithmetic helpers.
  function automatic logic [PA_W-1:0] join_addr(input logic [PFN_W-1:0] pfn,
                                                 input logic [PG_BITS-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic [MEM_AW-1:0] entry_addr(input logic [MEM_AW-1:0] b,
                                                   input logic [VPN_W-1:0] vpn);
    return b + MEM_AW'(vpn);
  endfunction

  function automatic logic in_bounds(input logic [VPN_W-1:0] vpn,
                                     input logic [MEM_AW-1:0] l);
    return MEM_AW'(vpn) < l;
  endfunction

  // Request split.
  logic [VPN_W-1:0]   vpn;
  logic [PG_BITS-1:0] off;
  assign vpn = req_vaddr[LA_W-1:PG_BITS];
  assign off = req_vaddr[PG_BITS-1:0];

  // Configuration.
  logic [MEM_AW-1:0] base, len;
  logic              flush;

  pgx_cfg #(.MEM_AW(MEM_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base(base), .len(len), .flush(flush)
  );

  // Lookup.
  logic               tlb_hit;
  logic [PFN_W-1:0]   tlb_pfn;
  logic [1:0]         tlb_prot;
  logic               fill_en;
  logic [TLB_N-1:0]   tlb_valid;
  logic [TLB_N-1:0]   tlb_match;
  logic [VPN_W-1:0]   vpn_q;
  logic [PG_BITS-1:0] off_q;
  logic [1:0]         kind_q;

  // Fields of the fetched entry.
  logic [PFN_W-1:0] pte_pfn;
  logic             pte_valid;
  logic [1:0]       pte_prot;
  assign pte_pfn   = mem_rdata[PFN_W-1:0];
  assign pte_valid = mem_rdata[PFN_W];
  assign pte_prot  = mem_rdata[PFN_W+2:PFN_W+1];

  pgx_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_vpn(vpn), .hit(tlb_hit), .hit_pfn(tlb_pfn), .hit_prot(tlb_prot),
    .fill_en(fill_en), .fill_vpn(vpn_q), .fill_pfn(pte_pfn), .fill_prot(pte_prot),
    .valid_vec(tlb_valid), .match_vec(tlb_match)
  );

  // Named events for the checker.
  logic accept, oob_evt, hit_evt, miss_evt, walk_done;
  assign accept   = req_valid && !busy;
  assign oob_evt  = accept && !in_bounds(vpn, len);
  assign hit_evt  = accept && !oob_evt && tlb_hit;
  assign miss_evt = accept && !oob_evt && !tlb_hit;

  pgx_walker #(.MEM_AW(MEM_AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(miss_evt),
    .start_addr(entry_addr(base, vpn)),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .done(walk_done)
  );

  assign busy = mem_req;

  // Pending request context and staleness after a flush during a walk.
  logic stale_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      off_q   <= '0;
      kind_q  <= '0;
      stale_q <= 1'b0;
    end else if (miss_evt) begin
      vpn_q   <= vpn;
      off_q   <= off;
      kind_q  <= req_kind;
      stale_q <= 1'b0;
    end else if (flush && busy) begin
      stale_q <= 1'b1;
    end
  end

  assign fill_en = walk_done && pte_valid && !stale_q && !flush;

  // Response formation.
  logic [1:0]      hit_flt, walk_flt, nxt_flt;
  logic [PA_W-1:0] nxt_paddr;
  logic            nxt_valid;

  assign hit_flt  = prot_fault(tlb_prot, req_kind);
  assign walk_flt = pte_valid ? prot_fault(pte_prot, kind_q) : FLT_INVALID;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_flt   = FLT_NONE;
    nxt_paddr = '0;
    if (oob_evt) begin
      nxt_valid = 1'b1;
      nxt_flt   = FLT_BOUNDS;
    end else if (hit_evt) begin
      nxt_valid = 1'b1;
      nxt_flt   = hit_flt;
      if (hit_flt == FLT_NONE) nxt_paddr = join_addr(tlb_pfn, off);
    end else if (walk_done) begin
      nxt_valid = 1'b1;
      nxt_flt   = walk_flt;
      if (walk_flt == FLT_NONE) nxt_paddr = join_addr(pte_pfn, off_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= nxt_valid;
      rsp_fault <= nxt_flt;
      rsp_paddr <= nxt_paddr;
    end
  end

endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
  parameter int TLB_N  = 8,
  parameter int PA_W   = 20,
  parameter int MEM_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              busy,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              hit_evt,
  input logic              oob_evt,
  input logic [TLB_N-1:0]  tlb_valid,
  input logic [TLB_N-1:0]  tlb_match
);

  p_fault_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (rsp_valid && !mem_req));

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_match));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_ack_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (rsp_valid && !busy));

  p_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oob_evt |=> (rsp_valid && rsp_fault == 2'd1 && !mem_req));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (tlb_valid == '0));

  p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);

endmodule

bind pgxlate_unit pgx_checker #(.TLB_N(TLB_N), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .hit_evt(hit_evt), .oob_evt(oob_evt),
  .tlb_valid(tlb_valid), .tlb_match(tlb_match)
);

// File: tb/pgxlate_unit_bench.sv
module pgxlate_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LA_W    = 12;
  localparam int PG_BITS = 9;
  localparam int PA_W    = 13;
  localparam int TLB_N   = 4;
  localparam int MEM_AW  = 8;
  localparam int PFN_W   = PA_W - PG_BITS;
  localparam int PTE_W   = PFN_W + 3;
  localparam int NPAGES  = 1 << (LA_W - PG_BITS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic busy, rsp_valid, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [MEM_AW-1:0] cfg_wdata = '0;
  logic [MEM_AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [PTE_W-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgxlate_unit #(.LA_W(LA_W), .PG_BITS(PG_BITS), .PA_W(PA_W), .TLB_N(TLB_N),
                 .MEM_AW(MEM_AW)) u_pgxlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  int reads = 0;
  int last_addr = 0;
  int wait_cnt = 0;
  int cur_base = 0, cur_len = 0;
  int res_pg [TLB_N];
  bit res_v [TLB_N];
  int rr = 0;

  // Table contents are a function of the entry address.
  function automatic int pt_frame(input int a); return (a * 7 + 1) % (1 << PFN_W); endfunction
  function automatic bit pt_valid(input int a); return (a % 5) != 3; endfunction
  function automatic int pt_prot(input int a);  return a % 4; endfunction

  function automatic bit permits(input int prot, input int kind);
    case (prot)
      0: return (kind == 0) || (kind == 2);
      1: return kind != 3;
      2: return kind == 2;
      default: return 1'b0;
    endcase
  endfunction

  // Memory model: acknowledge two cycles after a request appears.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req) begin
      if (wait_cnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= {2'(pt_prot(int'(mem_addr))), pt_valid(int'(mem_addr)),
                      PFN_W'(pt_frame(int'(mem_addr)))};
        reads     <= reads + 1;
        last_addr <= int'(mem_addr);
      end
      wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < TLB_N; i++) res_v[i] = 1'b0;
    rr = 0;
  endtask

  function automatic bit model_has(input int p);
    for (int i = 0; i < TLB_N; i++) if (res_v[i] && res_pg[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = MEM_AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) cur_len = val; else cur_base = val;
    model_flush();
  endtask

  task automatic xlate(input int p, input int kind, input int ofs);
    int r0, lat, a, exp_flt, exp_pa, exp_reads;
    bit resident;
    r0 = reads;
    resident = model_has(p);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = LA_W'((p << PG_BITS) | ofs); req_kind = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    a = cur_base + p;
    exp_pa = 0;
    if (p >= cur_len) begin
      exp_flt = 1; exp_reads = 0;
    end else begin
      exp_reads = resident ? 0 : 1;
      if (!pt_valid(a)) exp_flt = 2;
      else if (!permits(pt_prot(a), kind)) exp_flt = 3;
      else begin exp_flt = 0; exp_pa = (pt_frame(a) << PG_BITS) | ofs; end
      if (!resident && pt_valid(a)) begin
        res_pg[rr] = p; res_v[rr] = 1'b1; rr = (rr + 1) % TLB_N;
      end
    end
    check("R9 response arrives", rsp_valid, int'(rsp_valid), 1);
    case (exp_flt)
      1: check("R4 bounds fault", int'(rsp_fault) == exp_flt, int'(rsp_fault), exp_flt);
      2: check("R5 invalid fault", int'(rsp_fault) == exp_flt, int'(rsp_fault), exp_flt);
      3: check("R6 protection fault", int'(rsp_fault) == exp_flt, int'(rsp_fault), exp_flt);
      default: check("R6 access permitted", int'(rsp_fault) == 0, int'(rsp_fault), 0);
    endcase
    check("R1 physical address", int'(rsp_paddr) == exp_pa, int'(rsp_paddr), exp_pa);
    check("R8 R2 R3 memory reads", (reads - r0) == exp_reads, reads - r0, exp_reads);
    if (exp_reads == 1)
      check("R3 entry address", last_addr == (a % (1 << MEM_AW)), last_addr, a);
    if (exp_reads == 0 && p < cur_len)
      check("R2 hit latency", lat == 1, lat, 1);
    if (p >= cur_len)
      check("R4 bounds latency", lat == 1, lat, 1);
  endtask

  task automatic sweep();
    for (int pass = 0; pass < 2; pass++)
      for (int p = 0; p < NPAGES; p++)
        for (int k = 0; k < 3; k++)
          xlate(p, k, (p * 37 + k * 5 + pass * 101) % (1 << PG_BITS));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int r0;
    model_flush();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy low", busy == 1'b0, int'(busy), 0);
    check("R10 no response", rsp_valid == 1'b0, int'(rsp_valid), 0);
    check("R10 no memory request", mem_req == 1'b0, int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    xlate(0, 0, 3);  // length zero after reset: R10 bounds

    // Sweep with bounds edge between pages 5 and 6.
    cfg_write(1'b0, 16);
    cfg_write(1'b1, 6);
    sweep();
    // Base change: R7 flush, full-length table.
    cfg_write(1'b0, 35);
    cfg_write(1'b1, NPAGES);
    sweep();

    // R7: length write alone empties the buffer.
    xlate(1, 0, 8);
    xlate(1, 0, 9);
    r0 = reads;
    cfg_write(1'b1, NPAGES);
    xlate(1, 0, 10);
    check("R7 refetch after length write", reads - r0 == 1, reads - r0, 1);

    // R9: requests during a walk are ignored.
    cfg_write(1'b0, 16);
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = LA_W'((4 << PG_BITS) | 7); req_kind = 2'd0;
    @(negedge clk);
    check("R9 busy after miss", busy == 1'b1, int'(busy), 1);
    req_vaddr = LA_W'((5 << PG_BITS) | 1);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    check("R9 first request served", int'(rsp_paddr) == ((pt_frame(20) << PG_BITS) | 7),
          int'(rsp_paddr), (pt_frame(20) << PG_BITS) | 7);
    check("R9 single read", reads - r0 == 1, reads - r0, 1);
    @(negedge clk);
    check("R9 no extra response", rsp_valid == 1'b0, int'(rsp_valid), 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule